// File: doc/BRIEF.md
# Pseudo-static RAM access controller

This block sits between a synchronous host and an asynchronous pseudo-static RAM whose address bus is not multiplexed. It takes one request at a time over a valid/ready handshake. A request is a read, a write, or a read-modify-write. The block turns it into a sequence of chip-enable, write-enable and shared output-enable/refresh strobes. Every edge of that sequence is placed a whole number of clock cycles from the edge before it. Each minimum interval is given in nanoseconds as a parameter and rounded up to clock cycles at elaboration. The result comes back with a one-cycle done pulse, and reads also return their data.

An external scheduler asks for refresh by pulsing a request line. The block records the request. It then fits a refresh cycle in between accesses: the chip enable stays high and the shared strobe is pulled low. A recorded refresh request takes priority over a new host request. The block drives the memory data lines only after the memory's outputs have been turned off.

Top module: `psram_ctrl`

## Requirements
All cycle counts are for the default parameters and a 10 ns clock. Operation codes on `req_op`: 0 = read, 1 = write, 2 = read-modify-write, 3 = treated as read.
- R1: While reset is held and on the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_rf_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: A read holds `mem_ce_n` and `mem_oe_rf_n` low together for 9 cycles with `mem_we_n` high. It samples `mem_dq_i` on the edge that releases them. `rsp_done` is then high for exactly one cycle, the first cycle with chip enable high, and `rsp_rdata` carries the sampled byte.
- R3: A write holds chip enable low for 9 cycles and keeps `mem_oe_rf_n` high. `mem_we_n` goes low one cycle after chip enable falls and stays low for 3 cycles. The memory stores `req_wdata` at `req_addr` when write enable rises.
- R4: `mem_dq_oe` is high only while chip enable is low and the shared strobe is high. It rises only after a cycle in which write enable was already low. It stays high in the cycle in which write enable rises, so the data is held with zero hold time.
- R5: A read-modify-write uses one chip-enable-low span of 15 cycles. The output enable is low for the first 8 cycles, and the old byte is sampled at their end. Write enable is then low for 4 cycles. The host receives the old byte, and the memory then holds `req_wdata`.
- R6: Between two accesses, chip enable stays high for at least 7 cycles. `req_ready` is 0 until that precharge has been met.
- R7: `mem_addr` carries the accepted request address from the cycle in which chip enable falls. It does not change while chip enable is low.
- R8: A refresh pulses `mem_oe_rf_n` low for 8 cycles while `mem_ce_n` stays high. It starts no sooner than 7 cycles after chip enable rose. Next comes a shared-strobe-high recovery of 8 cycles, and then a one-cycle `rfsh_ack`.
- R9: If a refresh request and a host request are both waiting, the refresh cycle completes (`rfsh_ack`) before chip enable falls for the host access.
- R10: `mem_we_n` is never low together with `mem_oe_rf_n`, and never while chip enable is high.
- R11: The time from one chip-enable fall to the next covers at least the random cycle time, which is 16 cycles for read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_op | input | 2 | Operation code (0 read, 1 write, 2 read-modify-write) |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` for reads and read-modify-writes |
| rfsh_req | input | 1 | Refresh request pulse from the scheduler |
| rfsh_ack | output | 1 | One-cycle pulse when a refresh cycle has finished |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_rf_n | output | 1 | Shared output enable / refresh strobe, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the data driver toward the memory |
| mem_dq_i | input | 8 | Data read from the memory |

## Verification
The assertions check the safety rules of the strobes on every cycle. They check that write enable and the shared strobe are never low together, that write enable is low only under chip enable, and that the data driver is enabled only inside its window and holds past the write-enable rise. They also check that the address is steady while chip enable is low and that done pulses last a single cycle. Only the bench's scenarios can show the time-based properties: the exact pulse widths and precharge gaps, which byte ends up in the memory model, what data comes back, and the order in which a refresh and a host request are served. The bench checks these against a behavioural memory that returns data only after its access times.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RMW = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_RF_LOW,
    ST_RF_PRE
  } st_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_satcnt.sv
// Cycles since chip enable last rose, saturating at MAXV.
module psram_satcnt #(
  parameter int MAXV = 7,
  parameter int W    = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                 cnt <= W'(MAXV);
    else if (clr)            cnt <= W'(1);
    else if (cnt < W'(MAXV)) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/psram_dqpath.sv
// Write-data register, data driver enable and read capture.
module psram_dqpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drv_set,
  input  logic              drv_clr,
  input  logic              cap,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o  <= '0;
      dq_oe <= 1'b0;
      rdata <= '0;
    end else begin
      if (load)         dq_o  <= wdata;
      if (drv_set)      dq_oe <= 1'b1;
      else if (drv_clr) dq_oe <= 1'b0;
      if (cap)          rdata <= dq_i;
    end
  end
endmodule

// File: rtl/psram_fsm.sv
// Strobe sequencer and refresh arbiter; all timings in clock cycles.
module psram_fsm
  import psram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int PC_W   = 4,
  parameter int C_RC   = 16,
  parameter int C_RMW  = 22,
  parameter int C_CP   = 7,
  parameter int C_AH   = 2,
  parameter int C_CEA  = 8,
  parameter int C_OEA  = 3,
  parameter int C_OHZ  = 3,
  parameter int C_CW   = 8,
  parameter int C_WP   = 3,
  parameter int C_DW   = 2,
  parameter int C_RFD  = 7,
  parameter int C_FAP  = 8,
  parameter int C_FP   = 4,
  parameter int C_FC   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              rfsh_req,
  output logic              rfsh_ack,
  input  logic [PC_W-1:0]   pc_val,
  output logic              pc_clr,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic              load,
  output logic              drv_set,
  output logic              drv_clr,
  output logic              cap,
  output logic              done
);
  // Edge numbers counted from the chip-enable fall (edge 1 = first edge after it).
  localparam int L_RD  = imax(imax(C_CEA, C_OEA), imax(C_RC - C_CP, C_AH));
  localparam int W_WR  = imax(C_WP + 1, C_DW + 2);
  localparam int E_WR  = imax(W_WR + 1, imax(C_RC - C_CP, imax(C_CW, C_AH)));
  localparam int R_M   = imax(imax(C_CEA, C_OEA), C_AH);
  localparam int D_M   = R_M + imax(C_OHZ, 2);
  localparam int W_M   = imax(R_M + 1 + C_WP, D_M + C_DW);
  localparam int E_M   = imax(W_M + 1, imax(C_RMW - C_CP, C_CW));
  localparam int L_FP  = imax(C_FP, C_FC - C_FAP);
  localparam int GO_RF = imax(C_CP, C_RFD);
  localparam int MAXE  = imax(imax(E_M, E_WR), imax(L_RD, imax(C_FAP, L_FP)));
  localparam int CW    = $clog2(MAXE + 1) + 1;

  st_e           st;
  op_e           op;
  op_e           op_in;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          rf_go, accept, end_acc, we_fall, we_rise, oe_rise;

  assign op_in   = (req_op == 2'd1) ? OP_WR : (req_op == 2'd2) ? OP_RMW : OP_RD;
  assign rf_go   = (st == ST_IDLE) && pend && (pc_val >= PC_W'(GO_RF));
  assign req_ready = (st == ST_IDLE) && (pc_val >= PC_W'(C_CP)) && !pend && !rfsh_req;
  assign accept  = req_valid && req_ready;
  assign load    = accept;

  always_comb begin
    end_acc = 1'b0;
    we_fall = 1'b0;
    we_rise = 1'b0;
    oe_rise = 1'b0;
    drv_set = 1'b0;
    cap     = 1'b0;
    if (st == ST_ACC) begin
      case (op)
        OP_WR: begin
          we_fall = (cnt == CW'(1));
          drv_set = (cnt == CW'(2));
          we_rise = (cnt == CW'(W_WR));
          end_acc = (cnt == CW'(E_WR));
        end
        OP_RMW: begin
          cap     = (cnt == CW'(R_M));
          oe_rise = (cnt == CW'(R_M));
          we_fall = (cnt == CW'(R_M + 1));
          drv_set = (cnt == CW'(D_M));
          we_rise = (cnt == CW'(W_M));
          end_acc = (cnt == CW'(E_M));
        end
        default: begin
          cap     = (cnt == CW'(L_RD));
          end_acc = (cnt == CW'(L_RD));
        end
      endcase
    end
  end

  assign drv_clr = end_acc;
  assign pc_clr  = end_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op       <= OP_RD;
      cnt      <= '0;
      pend     <= 1'b0;
      ce_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      addr     <= '0;
      done     <= 1'b0;
      rfsh_ack <= 1'b0;
    end else begin
      done     <= 1'b0;
      rfsh_ack <= 1'b0;
      pend     <= (pend && !rf_go) || rfsh_req;
      case (st)
        ST_IDLE: begin
          if (rf_go) begin
            oe_n <= 1'b0;
            cnt  <= CW'(1);
            st   <= ST_RF_LOW;
          end else if (accept) begin
            op   <= op_in;
            addr <= req_addr;
            ce_n <= 1'b0;
            oe_n <= (op_in == OP_WR);
            cnt  <= CW'(1);
            st   <= ST_ACC;
          end
        end
        ST_ACC: begin
          cnt <= cnt + CW'(1);
          if (we_fall) we_n <= 1'b0;
          if (we_rise) we_n <= 1'b1;
          if (oe_rise) oe_n <= 1'b1;
          if (end_acc) begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_RF_LOW: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(C_FAP)) begin
            oe_n <= 1'b1;
            cnt  <= CW'(1);
            st   <= ST_RF_PRE;
          end
        end
        default: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(L_FP)) begin
            rfsh_ack <= 1'b1;
            st       <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R9: a refresh pulse never starts while a host access is in progress
  p_rf_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RF_LOW) |-> ce_n);

  // R2: done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 160,
  parameter int T_RMW_NS      = 220,
  parameter int T_CP_NS       = 70,
  parameter int T_AH_NS       = 20,
  parameter int T_CEA_NS      = 80,
  parameter int T_OEA_NS      = 30,
  parameter int T_OHZ_NS      = 25,
  parameter int T_CW_NS       = 80,
  parameter int T_WP_NS       = 25,
  parameter int T_DW_NS       = 20,
  parameter int T_RFD_NS      = 70,
  parameter int T_FAP_NS      = 80,
  parameter int T_FP_NS       = 40,
  parameter int T_FC_NS       = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              rfsh_req,
  output logic              rfsh_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_rf_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int C_RC   = ns2cyc(T_RC_NS,  CLK_PERIOD_NS);
  localparam int C_RMW  = ns2cyc(T_RMW_NS, CLK_PERIOD_NS);
  localparam int C_CP   = ns2cyc(T_CP_NS,  CLK_PERIOD_NS);
  localparam int C_AH   = ns2cyc(T_AH_NS,  CLK_PERIOD_NS);
  localparam int C_CEA  = ns2cyc(T_CEA_NS, CLK_PERIOD_NS);
  localparam int C_OEA  = ns2cyc(T_OEA_NS, CLK_PERIOD_NS);
  localparam int C_OHZ  = ns2cyc(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int C_CW   = ns2cyc(T_CW_NS,  CLK_PERIOD_NS);
  localparam int C_WP   = ns2cyc(T_WP_NS,  CLK_PERIOD_NS);
  localparam int C_DW   = ns2cyc(T_DW_NS,  CLK_PERIOD_NS);
  localparam int C_RFD  = ns2cyc(T_RFD_NS, CLK_PERIOD_NS);
  localparam int C_FAP  = ns2cyc(T_FAP_NS, CLK_PERIOD_NS);
  localparam int C_FP   = ns2cyc(T_FP_NS,  CLK_PERIOD_NS);
  localparam int C_FC   = ns2cyc(T_FC_NS,  CLK_PERIOD_NS);
  localparam int PC_MAX = imax(C_CP, C_RFD);
  localparam int PC_W   = $clog2(PC_MAX + 1) + 1;

  logic [PC_W-1:0] pc_val;
  logic            pc_clr, load, drv_set, drv_clr, cap;

  psram_satcnt #(.MAXV(PC_MAX), .W(PC_W)) u_pchg (
    .clk (clk),
    .rst (rst),
    .clr (pc_clr),
    .cnt (pc_val)
  );

  psram_fsm #(
    .ADDR_W(ADDR_W), .PC_W(PC_W),
    .C_RC(C_RC), .C_RMW(C_RMW), .C_CP(C_CP), .C_AH(C_AH),
    .C_CEA(C_CEA), .C_OEA(C_OEA), .C_OHZ(C_OHZ), .C_CW(C_CW),
    .C_WP(C_WP), .C_DW(C_DW), .C_RFD(C_RFD), .C_FAP(C_FAP),
    .C_FP(C_FP), .C_FC(C_FC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rfsh_req  (rfsh_req),
    .rfsh_ack  (rfsh_ack),
    .pc_val    (pc_val),
    .pc_clr    (pc_clr),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_rf_n),
    .addr      (mem_addr),
    .load      (load),
    .drv_set   (drv_set),
    .drv_clr   (drv_clr),
    .cap       (cap),
    .done      (rsp_done)
  );

  psram_dqpath #(.DATA_W(DATA_W)) u_dq (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .wdata   (req_wdata),
    .drv_set (drv_set),
    .drv_clr (drv_clr),
    .cap     (cap),
    .dq_i    (mem_dq_i),
    .dq_o    (mem_dq_o),
    .dq_oe   (mem_dq_oe),
    .rdata   (rsp_rdata)
  );

  // R10: write enable never overlaps the shared output-enable/refresh strobe
  p_we_oe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_rf_n);

  // R10: write enable only under chip enable
  p_we_under_ce_r10: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  // R4: driver only inside chip enable with memory outputs disabled
  p_drive_window_r4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_rf_n));

  // R4: driver turns on only after write enable has already been low
  p_drive_after_we_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_we_n) == 1'b0));

  // R4: data still driven in the cycle write enable rises
  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $rose(mem_we_n)) |-> mem_dq_oe);

  // R7: address steady while chip enable stays low
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R8: an access never begins while the refresh strobe is low
  p_ce_fall_no_rf_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> $past(mem_oe_rf_n));

endmodule

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        rfsh_req = 1'b0;
  logic        rfsh_ack;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_rf_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  psram_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rfsh_req(rfsh_req),
    .rfsh_ack(rfsh_ack), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_rf_n(mem_oe_rf_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory: 256 bytes on the low address bits, access-time aware.
  logic [7:0] mem [0:255];
  int lo, hi, wlo, olo, rlo;
  int last_lo, last_hi, last_wlo, last_olo, last_rlo, last_rfd;
  int viol, ack_cnt;
  logic [18:0] fall_addr, paddr;
  logic [7:0]  pdq;
  logic pce, pwe, poe, pdqoe;

  assign mem_dq_i = (!mem_ce_n && !mem_oe_rf_n && mem_we_n && lo >= 8 && olo >= 3)
                    ? mem[mem_addr[7:0]] : 8'hEE;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(negedge clk) begin
    if (rst) begin
      lo = 0; hi = 100; wlo = 0; olo = 0; rlo = 0;
      last_lo = 0; last_hi = 0; last_wlo = 0; last_olo = 0; last_rlo = 0; last_rfd = 0;
      viol = 0; ack_cnt = 0; fall_addr = '0;
      pce = 1'b1; pwe = 1'b1; poe = 1'b1; pdqoe = 1'b0; pdq = '0; paddr = '0;
    end else begin
      if (!mem_ce_n) begin
        if (pce) begin last_hi = hi; fall_addr = mem_addr; lo = 1; olo = 0; end
        else begin lo = lo + 1; if (mem_addr != paddr) viol = viol + 1; end
        if (!mem_oe_rf_n) olo = olo + 1;
      end else begin
        if (!pce) begin last_lo = lo; last_olo = olo; hi = 1; end
        else hi = hi + 1;
      end
      if (!mem_we_n) wlo = pwe ? 1 : wlo + 1;
      else if (!pwe) last_wlo = wlo;
      if (mem_ce_n && !mem_oe_rf_n) begin
        if (poe) begin rlo = 1; last_rfd = hi - 1; end
        else rlo = rlo + 1;
      end
      if (mem_ce_n && mem_oe_rf_n && !poe) last_rlo = rlo;
      if (!pce && !pwe && (mem_ce_n || mem_we_n)) begin
        if (!pdqoe || !mem_dq_oe) viol = viol + 1;
        mem[paddr[7:0]] = pdq;
      end
      if ((!mem_we_n && !mem_oe_rf_n) || (!mem_we_n && mem_ce_n) ||
          (mem_dq_oe && (mem_ce_n || !mem_oe_rf_n)))
        viol = viol + 1;
      if (rfsh_ack) ack_cnt = ack_cnt + 1;
      pce = mem_ce_n; pwe = mem_we_n; poe = mem_oe_rf_n;
      pdqoe = mem_dq_oe; pdq = mem_dq_o; paddr = mem_addr;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    for (int i = 0; i < 1000 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 1000 && !rsp_done; i++) @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ce_n in reset", int'(mem_ce_n), 1);
    rst = 1'b0;
    #2;
    chk("R1", "ce_n", int'(mem_ce_n), 1);
    chk("R1", "we_n", int'(mem_we_n), 1);
    chk("R1", "oe_rf_n", int'(mem_oe_rf_n), 1);
    chk("R1", "dq_oe", int'(mem_dq_oe), 0);
    chk("R1", "done", int'(rsp_done), 0);
    chk("R1", "ready", int'(req_ready), 1);
  endtask

  task automatic t_write_read();
    do_op(2'd1, 19'h00012, 8'hA5);
    chk("R3", "write ce low cycles", last_lo, 9);
    chk("R3", "write we low cycles", last_wlo, 3);
    chk("R3", "write oe low cycles", last_olo, 0);
    chk("R3", "memory byte", int'(mem[8'h12]), 8'hA5);
    chk("R7", "write address at ce fall", int'(fall_addr), 19'h00012);
    do_op(2'd0, 19'h00012, 8'h00);
    chk("R2", "read data", int'(rsp_rdata), 8'hA5);
    chk("R2", "read ce low cycles", last_lo, 9);
    chk("R2", "read oe low cycles", last_olo, 9);
    chk("R2", "done on first ce-high cycle", int'(rsp_done && mem_ce_n), 1);
    @(negedge clk);
    chk("R2", "done single cycle", int'(rsp_done), 0);
    do_op(2'd1, 19'h7FF34, 8'h3C);
    chk("R3", "second pattern byte", int'(mem[8'h34]), 8'h3C);
    do_op(2'd0, 19'h7FF34, 8'h00);
    chk("R2", "second read data", int'(rsp_rdata), 8'h3C);
    chk("R7", "read address at ce fall", int'(fall_addr), 19'h7FF34);
  endtask

  task automatic t_rmw();
    do_op(2'd2, 19'h00012, 8'h5A);
    chk("R5", "old byte returned", int'(rsp_rdata), 8'hA5);
    chk("R5", "rmw ce low cycles", last_lo, 15);
    chk("R5", "rmw oe low cycles", last_olo, 8);
    chk("R5", "rmw we low cycles", last_wlo, 4);
    chk("R5", "new byte stored", int'(mem[8'h12]), 8'h5A);
    do_op(2'd0, 19'h00012, 8'h00);
    chk("R5", "read after rmw", int'(rsp_rdata), 8'h5A);
  endtask

  task automatic t_b2b();
    do_op(2'd1, 19'h00055, 8'h77);
    chk("R6", "ready low in precharge", int'(req_ready), 0);
    do_op(2'd0, 19'h00055, 8'h00);
    chk("R6", "ce high gap", last_hi, 7);
    chk("R11", "ce fall to fall", last_hi + last_lo, 16);
    chk("R2", "back-to-back read data", int'(rsp_rdata), 8'h77);
  endtask

  task automatic t_refresh();
    int acks0;
    int ce_low_seen;
    acks0 = ack_cnt;
    ce_low_seen = 0;
    do_op(2'd1, 19'h00066, 8'h11);
    @(negedge clk);
    rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
    for (int i = 0; i < 200 && !rfsh_ack; i++) begin
      @(negedge clk);
      if (!mem_ce_n) ce_low_seen = 1;
    end
    #2;
    chk("R8", "refresh pulse cycles", last_rlo, 8);
    chk("R8", "ce high before refresh", last_rfd, 7);
    chk("R8", "ce stayed high", ce_low_seen, 0);
    chk("R8", "ack count", ack_cnt - acks0, 1);
    for (int i = 0; i < 20 && mem_oe_rf_n; i++) @(negedge clk);
    chk("R8", "no second refresh without request", int'(mem_oe_rf_n), 1);
  endtask

  task automatic t_priority();
    int seen_ce = 0;
    int ack_first = 0;
    int acc = 0;
    do_op(2'd1, 19'h00077, 8'hC3);
    @(negedge clk);
    rfsh_req = 1'b1; req_valid = 1'b1; req_op = 2'd0; req_addr = 19'h00077;
    for (int i = 0; i < 300 && !rsp_done; i++) begin
      @(negedge clk);
      if (i == 0) rfsh_req = 1'b0;
      if (!mem_ce_n) seen_ce = 1;
      if (rfsh_ack && !seen_ce) ack_first = 1;
      if (acc == 1) req_valid = 1'b0;
      if (req_valid && req_ready) acc = 1;
    end
    req_valid = 1'b0;
    #2;
    chk("R9", "refresh finished before access", ack_first, 1);
    chk("R9", "read after refresh", int'(rsp_rdata), 8'hC3);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_rmw();
    t_b2b();
    t_refresh();
    t_priority();
    chk("R10", "strobe/driver/address violations", viol, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule